// File: doc/BRIEF.md
# Posted Single-Entry Store Buffer

This block sits between a processor's external memory request channel and one shared RAM port. A plain store to RAM is posted: the block takes the address, write data and byte-enable mask into one holding slot and acknowledges the processor in the same cycle. The slot is then written to RAM through the shared port. Stores to the memory-mapped I/O window are not posted. They go straight to the port and complete only when the RAM side acknowledges them.

Ordering is strict. While the slot holds a store, every later request waits until the slot's RAM write has been acknowledged. This covers instruction fetch, loads, atomics, page-table walks, prefetches and further stores. Loads never take data from the slot, and stores are never merged. Four saturating counters record how the slot is used: posted stores, completed drains, cycles the slot is occupied, and cycles a request is held off by the slot.

Top module: `posted_store_buffer`

## Requirements
- R1: A store (request class code 2) whose address lies outside the I/O window is acknowledged in the same cycle it is presented, provided the slot is empty. In that cycle the RAM port issues no request.
- R2: On the cycle after a store is posted, the RAM port presents a write of exactly the posted address, data and byte enables, with class code 2. It holds that write until the RAM side acknowledges it.
- R3: The slot becomes free in the cycle the RAM side acknowledges its write. A request that was waiting reaches the RAM port on the next cycle.
- R4: While the slot is occupied, no request of any class reaches the RAM port or is acknowledged. Requests leave in program order. The class codes are fetch 0, load 1, store 2, atomic 3, page walk 4 and prefetch 5.
- R5: A RAM store presented while the slot is occupied is stalled. It is posted in the first cycle the slot is empty, and no RAM request is issued in that cycle.
- R6: A store whose address matches the I/O window ((addr & MMIO_MASK) == MMIO_BASE; the default window is 0x1000_0000 to 0x1FFF_FFFF) goes directly to the port. It is acknowledged in the cycle of the RAM acknowledge and does not change the posted-store count.
- R7: A non-posted request returns the RAM port's read data when it is acknowledged. A load to the address of a posted store waits for the drain and gets the data from RAM.
- R8: The counters count, respectively: posted stores, slot writes acknowledged by RAM, cycles the slot is occupied, and cycles a request is presented while the slot is occupied.
- R9: After reset the slot is empty, all four counters read zero, and the RAM port is idle.
- R10: Each counter stops at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ack |
| cpu_kind | input | 3 | Request class code |
| cpu_addr | input | ADDR_W | Request byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack |
| ram_valid | output | 1 | RAM request present |
| ram_kind | output | 3 | Class code of the RAM request |
| ram_we | output | 1 | RAM request is a write |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_be | output | DATA_W/8 | RAM byte enables |
| ram_ack | input | 1 | RAM completes the current request |
| ram_rdata | input | DATA_W | RAM read data, valid with ram_ack |
| cnt_accepts | output | CNT_W | Posted stores |
| cnt_drains | output | CNT_W | Slot writes completed |
| cnt_held | output | CNT_W | Cycles slot occupied |
| cnt_stalls | output | CNT_W | Cycles a request was held off |

## Verification
The assertions assume two things about the neighbours. The processor keeps a request and its fields unchanged from the cycle it raises cpu_valid until the cycle of cpu_ack. The RAM side raises ram_ack only while ram_valid is high, and for one cycle per request. The bench meets both assumptions by construction. Its processor driver changes the request only after it has sampled the acknowledge. Its RAM model acknowledges after a programmable wait counted on a visible request and drops the acknowledge after one cycle. The stimulus places each request class directly behind a posted store, both to the same address and to other addresses, at several RAM latencies.

// File: rtl/psb_pkg.sv
package psb_pkg;

    typedef enum logic [2:0] {
        REQ_FETCH    = 3'd0,
        REQ_LOAD     = 3'd1,
        REQ_STORE    = 3'd2,
        REQ_ATOMIC   = 3'd3,
        REQ_WALK     = 3'd4,
        REQ_PREFETCH = 3'd5
    } req_kind_e;

    localparam int NUM_CTR    = 4;
    localparam int CTR_ACCEPT = 0;
    localparam int CTR_DRAIN  = 1;
    localparam int CTR_HELD   = 2;
    localparam int CTR_STALL  = 3;

endpackage

// File: rtl/psb_region_match.sv
module psb_region_match #(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W-1:0] MASK   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    assign hit = ((addr & MASK) == BASE);
endmodule

// File: rtl/psb_entry.sv
module psb_entry #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [BE_W-1:0]   cap_be,
    input  logic              retire,
    output logic              held,
    output logic [ADDR_W-1:0] ent_addr,
    output logic [DATA_W-1:0] ent_data,
    output logic [BE_W-1:0]   ent_be
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (retire) begin
            slot_d.valid = 1'b0;
        end
        if (capture) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = cap_addr;
            slot_d.data  = cap_data;
            slot_d.be    = cap_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign held     = slot_q.valid;
    assign ent_addr = slot_q.addr;
    assign ent_data = slot_q.data;
    assign ent_be   = slot_q.be;

    // A new store is only taken into an empty slot
    assert_capture_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !slot_q.valid);

    // Only an occupied slot can be retired
    assert_retire_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> slot_q.valid);

    // Contents do not move while the slot waits for its write
    assert_slot_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !retire) |=>
            (slot_q.valid && $stable(slot_q.addr) && $stable(slot_q.data) && $stable(slot_q.be)));
endmodule

// File: rtl/psb_sat_ctr.sv
module psb_sat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/posted_store_buffer.sv
module posted_store_buffer
    import psb_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] MMIO_BASE = ADDR_W'('h1000_0000),
    parameter logic [ADDR_W-1:0] MMIO_MASK = ADDR_W'('hF000_0000),
    localparam int               BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [2:0]        cpu_kind,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ram_valid,
    output logic [2:0]        ram_kind,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [BE_W-1:0]   ram_be,
    input  logic              ram_ack,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [CNT_W-1:0]  cnt_accepts,
    output logic [CNT_W-1:0]  cnt_drains,
    output logic [CNT_W-1:0]  cnt_held,
    output logic [CNT_W-1:0]  cnt_stalls
);
    logic              io_hit;
    logic              is_store;
    logic              post_cand;
    logic              post_now;
    logic              pass_now;
    logic              drain_done;
    logic              slot_held;
    logic [ADDR_W-1:0] slot_addr;
    logic [DATA_W-1:0] slot_data;
    logic [BE_W-1:0]   slot_be;
    logic [NUM_CTR-1:0] ctr_inc;
    logic [CNT_W-1:0]   ctr_val [NUM_CTR];

    psb_region_match #(
        .ADDR_W (ADDR_W),
        .BASE   (MMIO_BASE),
        .MASK   (MMIO_MASK)
    ) u_region (
        .addr (cpu_addr),
        .hit  (io_hit)
    );

    always_comb begin
        is_store   = (cpu_kind == REQ_STORE);
        post_cand  = cpu_valid && is_store && !io_hit;
        post_now   = post_cand && !slot_held;
        pass_now   = cpu_valid && !post_cand && !slot_held;
        drain_done = slot_held && ram_ack;
    end

    psb_entry #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (post_now),
        .cap_addr (cpu_addr),
        .cap_data (cpu_wdata),
        .cap_be   (cpu_be),
        .retire   (drain_done),
        .held     (slot_held),
        .ent_addr (slot_addr),
        .ent_data (slot_data),
        .ent_be   (slot_be)
    );

    always_comb begin
        if (slot_held) begin
            ram_valid = 1'b1;
            ram_kind  = REQ_STORE;
            ram_we    = 1'b1;
            ram_addr  = slot_addr;
            ram_wdata = slot_data;
            ram_be    = slot_be;
        end else begin
            ram_valid = pass_now;
            ram_kind  = cpu_kind;
            ram_we    = pass_now && is_store;
            ram_addr  = cpu_addr;
            ram_wdata = cpu_wdata;
            ram_be    = cpu_be;
        end
        cpu_ack   = post_now || (pass_now && ram_ack);
        cpu_rdata = ram_rdata;
    end

    always_comb begin
        ctr_inc             = '0;
        ctr_inc[CTR_ACCEPT] = post_now;
        ctr_inc[CTR_DRAIN]  = drain_done;
        ctr_inc[CTR_HELD]   = slot_held;
        ctr_inc[CTR_STALL]  = cpu_valid && slot_held;
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        psb_sat_ctr #(
            .W (CNT_W)
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ctr_inc[g]),
            .count (ctr_val[g])
        );
    end

    assign cnt_accepts = ctr_val[CTR_ACCEPT];
    assign cnt_drains  = ctr_val[CTR_DRAIN];
    assign cnt_held    = ctr_val[CTR_HELD];
    assign cnt_stalls  = ctr_val[CTR_STALL];

    assert_post_same_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_kind == REQ_STORE && !io_hit && !slot_held) |-> (cpu_ack && !ram_valid));

    assert_posted_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_kind == REQ_STORE && !io_hit && !slot_held) |=>
            (ram_valid && ram_we && ram_kind == REQ_STORE && ram_addr == $past(cpu_addr)
             && ram_wdata == $past(cpu_wdata) && ram_be == $past(cpu_be)));

    assert_free_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_held && ram_ack) |=> !slot_held);

    assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && slot_held) |-> (!cpu_ack && ram_we && ram_kind == REQ_STORE));

    assert_io_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_kind == REQ_STORE && io_hit && !slot_held) |->
            (ram_valid && ram_we && ram_addr == cpu_addr && cpu_ack == ram_ack));

    assert_read_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_kind != REQ_STORE && !slot_held && ram_ack) |->
            (cpu_ack && cpu_rdata == ram_rdata));
endmodule

// File: tb/posted_store_buffer_bench.sv
`timescale 1ns/1ps
module posted_store_buffer_bench;
    localparam logic [2:0] K_FETCH = 3'd0, K_LOAD = 3'd1, K_STORE = 3'd2,
                           K_ATOMIC = 3'd3, K_WALK = 3'd4, K_PREF = 3'd5;
    localparam int CW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [2:0]  cpu_kind = '0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        ram_valid;
    logic [2:0]  ram_kind;
    logic        ram_we;
    logic [31:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [3:0]  ram_be;
    logic        ram_ack = 1'b0;
    logic [31:0] ram_rdata = '0;
    logic [CW-1:0] cnt_accepts, cnt_drains, cnt_held, cnt_stalls;

    posted_store_buffer #(.CNT_W(CW)) u_posted_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .ram_valid(ram_valid), .ram_kind(ram_kind), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_be(ram_be), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
        .cnt_accepts(cnt_accepts), .cnt_drains(cnt_drains),
        .cnt_held(cnt_held), .cnt_stalls(cnt_stalls)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } txn_t;

    txn_t        exp_q[$];
    logic [31:0] mem    [256];
    logic [31:0] shadow [256];
    int          n_checks = 0;
    int          n_err = 0;
    int          ram_lat = 2;
    int          wcnt = 0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    // RAM model: acknowledge after ram_lat waiting cycles, one cycle wide
    always begin
        @(negedge clk); #1;
        if (ram_ack) begin
            ram_ack = 1'b0;
            wcnt    = 0;
        end else if (ram_valid) begin
            if (wcnt >= ram_lat) begin
                ram_ack   = 1'b1;
                ram_rdata = mem[ram_addr[9:2]];
                if (ram_we) mem[ram_addr[9:2]] = merge(mem[ram_addr[9:2]], ram_wdata, ram_be);
            end else begin
                wcnt++;
            end
        end
    end

    // Monitor: every completed RAM transaction must match the next expected one (R4 order)
    always begin
        txn_t e;
        @(negedge clk); #2;
        if (rst_n && ram_valid && ram_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected RAM transaction", ram_addr, 0);
            end else begin
                e = exp_q.pop_front();
                check(ram_we == e.we && ram_addr == e.addr, "R4 RAM order/address",
                      {31'd0, ram_we, ram_addr}, {31'd0, e.we, e.addr});
                if (e.we)
                    check(ram_wdata == e.data && ram_be == e.be, "R2 RAM write payload",
                          {28'd0, ram_be, ram_wdata}, {28'd0, e.be, e.data});
            end
        end
    end

    task automatic drive(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        cpu_valid = 1'b1; cpu_kind = k; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    endtask

    task automatic expect_txn(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        exp_q.push_back('{we: (k == K_STORE), addr: a, data: d, be: be});
        if (k == K_STORE) shadow[a[9:2]] = merge(shadow[a[9:2]], d, be);
    endtask

    task automatic wait_ack(output int n);
        n = 0;
        while (!cpu_ack && n < 200) begin @(negedge clk); #2; n++; end
        if (n >= 200) check(1'b0, "R4 request never acknowledged", n, 0);
    endtask

    task automatic cpu_op(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] expd;
        int n;
        expd = shadow[a[9:2]];
        expect_txn(k, a, d, be);
        @(negedge clk); drive(k, a, d, be); #2;
        wait_ack(n);
        if (k != K_STORE) check(cpu_rdata == expd, "R7 read data", cpu_rdata, expd);
        @(posedge clk); #1 cpu_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk); #2;
        // R9: reset state
        check(cnt_accepts == 0 && cnt_drains == 0 && cnt_held == 0 && cnt_stalls == 0,
              "R9 counters zero", {cnt_accepts, cnt_drains, cnt_held, cnt_stalls}, 0);
        check(!ram_valid && !cpu_ack, "R9 port idle", {ram_valid, cpu_ack}, 0);

        // Phase A: post, then a load to the same address waits for the drain
        ram_lat = 2;
        @(negedge clk);
        drive(K_STORE, 32'h100, 32'hA1A1_0001, 4'hF);
        expect_txn(K_STORE, 32'h100, 32'hA1A1_0001, 4'hF);
        #2;
        check(cpu_ack, "R1 same-cycle ack", cpu_ack, 1);
        check(!ram_valid, "R1 no RAM request at post", ram_valid, 0);
        @(negedge clk);
        drive(K_LOAD, 32'h100, 32'h0, 4'h0);
        expect_txn(K_LOAD, 32'h100, 32'h0, 4'h0);
        #2;
        check(ram_valid && ram_we && ram_kind == K_STORE && ram_addr == 32'h100 &&
              ram_wdata == 32'hA1A1_0001 && ram_be == 4'hF, "R2 slot write presented",
              {ram_valid, ram_we, ram_addr}, {2'b11, 32'h100});
        check(!cpu_ack, "R4 load held c1", cpu_ack, 0);
        @(negedge clk); #2;
        check(!cpu_ack && ram_we, "R4 load held c2", {cpu_ack, ram_we}, 2'b01);
        @(negedge clk); #2;
        check(ram_ack && !cpu_ack, "R4 load held during drain ack", {ram_ack, cpu_ack}, 2'b10);
        @(negedge clk); #2;
        check(ram_valid && !ram_we && ram_addr == 32'h100 && ram_kind == K_LOAD,
              "R3 waiting load issued next cycle", {ram_valid, ram_we, ram_addr}, {2'b10, 32'h100});
        wait_ack(n);
        check(cpu_rdata == 32'hA1A1_0001, "R7 load gets drained data from RAM", cpu_rdata, 32'hA1A1_0001);
        @(posedge clk); #1 cpu_valid = 1'b0;
        repeat (2) @(negedge clk); #2;
        check(cnt_accepts == 1 && cnt_drains == 1, "R8 accept/drain counts",
              {cnt_accepts, cnt_drains}, {5'd1, 5'd1});
        check(cnt_held == 3 && cnt_stalls == 3, "R8 held/stall counts",
              {cnt_held, cnt_stalls}, {5'd3, 5'd3});

        // Phase B: a store behind a full slot is stalled, then posted
        @(negedge clk);
        drive(K_STORE, 32'h104, 32'hB2B2_B2B2, 4'hF);
        expect_txn(K_STORE, 32'h104, 32'hB2B2_B2B2, 4'hF);
        #2;
        check(cpu_ack, "R1 second post", cpu_ack, 1);
        @(negedge clk);
        drive(K_STORE, 32'h108, 32'h0000_C3C3, 4'b0011);
        expect_txn(K_STORE, 32'h108, 32'h0000_C3C3, 4'b0011);
        #2;
        check(!cpu_ack, "R5 store stalled while full", cpu_ack, 0);
        wait_ack(n);
        check(n == 3, "R5 posted the cycle after drain ack", n, 3);
        check(!ram_valid, "R5 RAM idle when posting", ram_valid, 0);
        @(posedge clk); #1 cpu_valid = 1'b0;
        repeat (8) @(negedge clk);

        // Phase C: I/O store bypasses the slot
        @(negedge clk);
        drive(K_STORE, 32'h1000_0040, 32'h0000_00D4, 4'hF);
        expect_txn(K_STORE, 32'h1000_0040, 32'h0000_00D4, 4'hF);
        #2;
        check(ram_valid && ram_we && !cpu_ack, "R6 direct write, no early ack",
              {ram_valid, ram_we, cpu_ack}, 3'b110);
        wait_ack(n);
        check(ram_ack, "R6 ack coincides with RAM ack", ram_ack, 1);
        @(posedge clk); #1 cpu_valid = 1'b0;
        repeat (3) @(negedge clk); #2;
        check(cnt_accepts == 3, "R6 bypass not counted as post", cnt_accepts, 3);

        // Phase D: every class behind a posted store, several latencies (scoreboard)
        for (int lat = 0; lat < 4; lat++) begin
            logic [31:0] base;
            ram_lat = lat;
            base = 32'h200 + 32'(lat * 32);
            cpu_op(K_STORE,  base,        32'h1111_0000 + 32'(lat), 4'hF);
            cpu_op(K_FETCH,  base,        32'h0, 4'h0);
            cpu_op(K_STORE,  base + 4,    32'h2222_0000 + 32'(lat), 4'b1100);
            cpu_op(K_ATOMIC, base + 4,    32'h0, 4'h0);
            cpu_op(K_STORE,  base + 8,    32'h3333_0000 + 32'(lat), 4'b0101);
            cpu_op(K_WALK,   base + 8,    32'h0, 4'h0);
            cpu_op(K_STORE,  base + 12,   32'h4444_0000 + 32'(lat), 4'hF);
            cpu_op(K_PREF,   base + 16,   32'h0, 4'h0);
            cpu_op(K_STORE,  32'h1000_0080, 32'h5555_0000 + 32'(lat), 4'hF);
            cpu_op(K_LOAD,   base + 12,   32'h0, 4'h0);
        end
        repeat (10) @(negedge clk); #2;
        check(cnt_accepts == 19 && cnt_drains == 19, "R8 counts after mixed traffic",
              {cnt_accepts, cnt_drains}, {5'd19, 5'd19});

        // Phase E: saturation
        ram_lat = 1;
        for (int i = 0; i < 40; i++) cpu_op(K_STORE, 32'h300 + 32'(4 * (i % 8)), 32'(i), 4'hF);
        repeat (10) @(negedge clk); #2;
        check(cnt_accepts == 31 && cnt_drains == 31, "R10 accept/drain saturate",
              {cnt_accepts, cnt_drains}, {5'd31, 5'd31});
        check(cnt_held == 31 && cnt_stalls == 31, "R10 held/stall saturate",
              {cnt_held, cnt_stalls}, {5'd31, 5'd31});

        check(exp_q.size() == 0, "R3 all expected RAM transactions seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule